// File: doc/BRIEF.md
# Memory-Mapped GPIO Register Block

This block gives a small processor eight general-purpose pins through three byte-wide registers in its data address space. Four of the pins are outputs only and the other four can each be set as input or output. A direction register sets which of the four bidirectional pins are driven. An output register holds the value driven onto the pins. An input register shows the pin levels after they pass through a synchroniser.

The registers sit in a peripheral window that covers the top 4 KB of a 16-bit data space, where the upper address nibble is all ones. Inside the window only the three lowest address bits choose a register, so the 8-byte group repeats all the way through the window. Offsets 4 to 7 of each group belong to a neighbouring peripheral that is decoded elsewhere, so this block ignores them. Writes take effect at the rising clock edge on which the write strobe is high. Read data is combinational and follows the address.

Top module: `gpio_regblk`

## Requirements
- R1: While reset is held and just after it is released, the direction and output registers are 0x00: `pin_o` = 0x00 and `pin_oe` = 0xF0, so all bidirectional pins start as inputs.
- R2: An access is decoded only when `bus_addr[15:12]` = 4'hF. Outside this window `bus_rdata` is 0x00 and writes change nothing.
- R3: Inside the window only `bus_addr[2:0]` selects a register. Bits [11:3] have no effect on reads or writes.
- R4: Offset 0 is the direction register. A write stores `bus_wdata[3:0]`, and bits [7:4] read back as zero. Bit n = 1 sets `pin_oe[n]` = 1, making that pin an output. Bit n = 0 makes it an input.
- R5: `pin_oe[7:4]` is always 4'hF, whatever the direction register holds.
- R6: Offset 1 is the output register. A write stores the whole byte, a read returns it, and `pin_o` equals it at all times.
- R7: Offset 2 is the input register. Bits [3:0] show `pin_i[3:0]` through a two-flop synchroniser: a level sampled at one rising edge appears after the second rising edge and not after the first. Bits [7:4] show output register bits [7:4].
- R8: Writes to offset 2 have no effect.
- R9: Offset 3 (reserved) and offsets 4 to 7 read 0x00, and writes to them have no effect.
- R10: A register changes only at a rising edge with `bus_we` = 1. While `bus_we` = 0, address and data activity leave every register and `pin_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 16 | Data-bus address |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe, sampled at the rising edge |
| bus_rdata | output | 8 | Combinational read data |
| pin_o | output | 8 | Pin output values |
| pin_oe | output | 8 | Pin output enables (1 = drive) |
| pin_i | input | 4 | Raw levels of the bidirectional pins |

## Verification
The bench writes through mirrored addresses and then reads through different mirrors. A decoder that used too few address bits, or too many, would alias or lose registers, and this exposes it. It checks the synchroniser latency exactly at one and two edges after a pin change, so a missing stage or an extra stage shows up as a read that arrives one cycle early or late. It writes the input, reserved and neighbour offsets and addresses outside the window, then reads the registers back, which catches decode leaks that would corrupt the direction or output values. It also writes ones into the upper direction bits and checks that they never reach `pin_oe` or the read data.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int ADDR_W  = 16;
  localparam int DATA_W  = 8;
  localparam int BIDIR_N = 4;
  localparam int WIN_W   = 4;
  localparam int OFF_W   = 3;
  localparam logic [WIN_W-1:0] WIN_TAG = 4'hF;

  typedef enum logic [OFF_W-1:0] {
    OFF_DIR = 3'd0,
    OFF_OUT = 3'd1,
    OFF_IN  = 3'd2,
    OFF_RSV = 3'd3
  } reg_off_e;

  function automatic logic win_hit(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1 -: WIN_W] == WIN_TAG;
  endfunction

  function automatic logic [DATA_W-1:0] oe_vec(input logic [BIDIR_N-1:0] dir);
    return {{(DATA_W-BIDIR_N){1'b1}}, dir};
  endfunction

  function automatic logic [DATA_W-1:0] dir_view(input logic [BIDIR_N-1:0] dir);
    return {{(DATA_W-BIDIR_N){1'b0}}, dir};
  endfunction

  function automatic logic [DATA_W-1:0] in_view(input logic [BIDIR_N-1:0] syn,
                                                input logic [DATA_W-1:0]  outv);
    return {outv[DATA_W-1:BIDIR_N], syn};
  endfunction
endpackage

// File: rtl/gpio_addr_dec.sv
module gpio_addr_dec
  import gpio_pkg::*;
#(
  parameter int AW = ADDR_W
) (
  input  logic [AW-1:0] addr,
  input  logic          we,
  output logic          hit,
  output logic          sel_dir,
  output logic          sel_out,
  output logic          sel_in,
  output logic          sel_none,
  output logic          wr_dir,
  output logic          wr_out
);
  logic [OFF_W-1:0] off;
  logic unused_mid;

  assign unused_mid = ^addr[AW-WIN_W-1:OFF_W];
  assign off      = addr[OFF_W-1:0];
  assign hit      = win_hit(addr);
  assign sel_dir  = hit && (off == OFF_DIR);
  assign sel_out  = hit && (off == OFF_OUT);
  assign sel_in   = hit && (off == OFF_IN);
  assign sel_none = !(sel_dir || sel_out || sel_in);
  assign wr_dir   = we && sel_dir;
  assign wr_out   = we && sel_out;
endmodule

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) stg[0] <= '0;
          else        stg[0] <= d;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) stg[s] <= '0;
          else        stg[s] <= stg[s-1];
      end
    end
  endgenerate

  assign q = stg[STAGES-1];
endmodule

// File: rtl/gpio_regblk.sv
module gpio_regblk
  import gpio_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_we,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [DATA_W-1:0] pin_o,
  output logic [DATA_W-1:0] pin_oe,
  input  logic [BIDIR_N-1:0] pin_i
);
  logic               win_evt, sel_dir, sel_out, sel_in, sel_none;
  logic               wr_dir_evt, wr_out_evt;
  logic [BIDIR_N-1:0] dir_q;
  logic [DATA_W-1:0]  out_q;
  logic [BIDIR_N-1:0] sync_q;

  gpio_addr_dec #(.AW(ADDR_W)) u_dec (
    .addr     (bus_addr),
    .we       (bus_we),
    .hit      (win_evt),
    .sel_dir  (sel_dir),
    .sel_out  (sel_out),
    .sel_in   (sel_in),
    .sel_none (sel_none),
    .wr_dir   (wr_dir_evt),
    .wr_out   (wr_out_evt)
  );

  gpio_sync #(.W(BIDIR_N), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (pin_i),
    .q     (sync_q)
  );

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)          dir_q <= '0;
    else if (wr_dir_evt) dir_q <= bus_wdata[BIDIR_N-1:0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)          out_q <= '0;
    else if (wr_out_evt) out_q <= bus_wdata;

  always_comb begin
    bus_rdata = '0;
    if (sel_dir)      bus_rdata = dir_view(dir_q);
    else if (sel_out) bus_rdata = out_q;
    else if (sel_in)  bus_rdata = in_view(sync_q, out_q);
  end

  assign pin_o  = out_q;
  assign pin_oe = oe_vec(dir_q);
endmodule

// File: rtl/gpio_regblk_chk.sv
module gpio_regblk_chk
  import gpio_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic [DATA_W-1:0]  bus_wdata,
  input logic [DATA_W-1:0]  bus_rdata,
  input logic [DATA_W-1:0]  pin_o,
  input logic [DATA_W-1:0]  pin_oe,
  input logic [BIDIR_N-1:0] pin_i,
  input logic [BIDIR_N-1:0] sync_q,
  input logic               win_evt,
  input logic               sel_none,
  input logic               wr_dir_evt,
  input logic               wr_out_evt
);
  logic [1:0] cyc;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)          cyc <= '0;
    else if (cyc != 2'd2) cyc <= cyc + 2'd1;

  // R2
  outside_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !win_evt |-> bus_rdata == '0);

  // R9
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel_none |-> bus_rdata == '0);

  // R4
  dir_to_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_dir_evt |=> pin_oe[BIDIR_N-1:0] == $past(bus_wdata[BIDIR_N-1:0]));

  // R5
  oe_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pin_oe[DATA_W-1:BIDIR_N] == '1);

  // R10
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_out_evt |=> $stable(pin_o));

  // R6
  out_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_out_evt |=> pin_o == $past(bus_wdata));

  // R7
  sync_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc == 2'd2) |-> sync_q == $past(pin_i, 2));
endmodule

bind gpio_regblk gpio_regblk_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_wdata  (bus_wdata),
  .bus_rdata  (bus_rdata),
  .pin_o      (pin_o),
  .pin_oe     (pin_oe),
  .pin_i      (pin_i),
  .sync_q     (sync_q),
  .win_evt    (win_evt),
  .sel_none   (sel_none),
  .wr_dir_evt (wr_dir_evt),
  .wr_out_evt (wr_out_evt)
);

// File: tb/tb_gpio_regblk.sv
module tb_gpio_regblk;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic        bus_we = 1'b0;
  logic [7:0]  bus_rdata, pin_o, pin_oe;
  logic [3:0]  pin_i = '0;

  int checks = 0;
  int errors = 0;
  logic [3:0] m_dir = '0;
  logic [7:0] m_out = '0;
  bit done = 0;

  always #5 clk = ~clk;

  gpio_regblk dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_rdata(bus_rdata), .pin_o(pin_o), .pin_oe(pin_oe),
    .pin_i(pin_i)
  );

  function automatic logic in_win(input logic [15:0] a);
    return a >= 16'hF000;
  endfunction

  function automatic logic [7:0] exp_read(input logic [15:0] a);
    if (!in_win(a)) return 8'h00;
    case (a % 8)
      0: return {4'h0, m_dir};
      1: return m_out;
      2: return {m_out[7:4], pin_i};
      default: return 8'h00;
    endcase
  endfunction

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
    if (in_win(a) && a % 8 == 0) m_dir = d[3:0];
    if (in_win(a) && a % 8 == 1) m_out = d;
  endtask

  task automatic rd(input string req, input logic [15:0] a);
    @(negedge clk);
    bus_addr = a;
    #1;
    chk(req, bus_rdata, exp_read(a));
  endtask

  task automatic pins_chk(input string req);
    chk(req, pin_o, m_out);
    chk(req, pin_oe, {4'hF, m_dir});
  endtask

  task automatic set_pins(input logic [3:0] v);
    @(negedge clk);
    pin_i = v;
    repeat (3) @(negedge clk);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240607));
    repeat (3) @(negedge clk);
    // R1: reset state while held
    chk("R1", pin_o, 8'h00);
    chk("R1", pin_oe, 8'hF0);
    rst_n = 1'b1;
    rd("R1", 16'hF000);
    rd("R1", 16'hF001);
    pins_chk("R1");

    // R4 upper direction bits dropped; R5
    wr(16'hF000, 8'hFA);
    rd("R4", 16'hF000);
    pins_chk("R4");
    chk("R5", pin_oe[7:4], 4'hF);
    // R6 and R3 mirror
    wr(16'hF7F9, 8'hA5);
    rd("R6", 16'hF001);
    rd("R3", 16'hFFF9);
    pins_chk("R6");

    // R7 exact synchroniser latency
    @(negedge clk);
    bus_addr = 16'hF002;
    pin_i = 4'h9;
    @(negedge clk); #1;
    chk("R7 one edge", bus_rdata, {m_out[7:4], 4'h0});
    @(negedge clk); #1;
    chk("R7 two edges", bus_rdata, {m_out[7:4], 4'h9});

    // R8 write to input register ignored
    wr(16'hF00A, 8'h33);
    rd("R8", 16'hF001);
    rd("R8", 16'hF000);
    rd("R8", 16'hF002);
    // R9 reserved and neighbour offsets
    for (int o = 3; o < 8; o++) begin
      wr(16'hF000 + 16'(o), 8'hFF);
      rd("R9", 16'hF000 + 16'(o));
      pins_chk("R9");
    end
    // R2 outside window
    wr(16'hE001, 8'h00);
    wr(16'h0000, 8'h0F);
    rd("R2", 16'hE001);
    rd("R2", 16'h7000);
    pins_chk("R2");
    // R10 strobe low
    @(negedge clk);
    bus_addr = 16'hF001; bus_wdata = 8'h12; bus_we = 1'b0;
    @(negedge clk);
    bus_addr = 16'hF000; bus_wdata = 8'h00;
    @(negedge clk);
    pins_chk("R10");

    // random mix
    for (int i = 0; i < 500; i++) begin
      logic [15:0] a;
      logic [7:0]  d;
      int r = $urandom % 100;
      a = {($urandom % 100 < 85) ? 4'hF : 4'($urandom % 15), 12'($urandom)};
      d = 8'($urandom);
      if (r < 10) set_pins(4'($urandom));
      else if (r < 55) wr(a, d);
      rd("R3", a);
      pins_chk("R6");
    end
    finish_run();
  end
endmodule